// File: doc/BRIEF.md
# Set-associative instruction cache controller

This block is a read-only instruction cache placed between a processor fetch port and a bus master port that carries one transaction at a time. A fetch that hits returns its instruction word in the cycle it is presented, with no stall. A fetch that misses holds the processor stalled. The block then issues one read burst that covers the whole line, writes the returned words into the chosen way, and finally hands back the requested word with the stall released.

An address-decode input marks a fetch as uncached. Such a fetch skips the array entirely. It produces a single-word read, and the processor stays stalled until that word comes back. The array is never written by the processor and the block never issues a bus write.

Parameters set the number of sets (`SETS`, a power of two from 2 to 1024), the words per line (`WORDS`, a power of two from 2 to 32) and the associativity (`WAYS`, a power of two from 1 to 16). Bus address and data are 32 bits wide, and each response beat carries a one-bit error flag. The processor holds `fetch_req` and its address until a cycle in which `fetch_stall` is low. That cycle delivers `fetch_rdata` and `fetch_berr`.

Top module: `ifetch_cache`

## Requirements
- R1: A cached fetch that hits a valid line returns the addressed word in the same cycle, with `fetch_stall` low, and starts no bus command.
- R2: A cached fetch that misses raises `bus_req` with `bus_len` equal to `WORDS`. `bus_addr` is the line base, so address bits [log2(WORDS)+1:0] are zero. `fetch_stall` stays high until the word is returned.
- R3: A fetch with `fetch_uncached` high issues a command with `bus_len` equal to 1 and `bus_addr` equal to the fetch address with bits [1:0] cleared. It returns the response word and fills no line, so a later cached fetch of that address still misses.
- R4: Only one transaction is in flight. While `bus_req` waits for `bus_gnt`, the address and length stay stable. After a grant, `bus_req` stays low until every response beat has arrived.
- R5: Response beat k of a line fill is stored as word k of the line, and the requested word is returned only after the final beat.
- R6: Each set keeps a round-robin victim pointer that starts at way 0 and advances by one way, wrapping, on every error-free fill of that set.
- R7: If any beat of a transaction carries the error flag, the return cycle shows `fetch_berr` high with `fetch_stall` low. The line being filled stays invalid, so the next fetch to it misses again.
- R8: After reset the block spends `SETS` cycles clearing every valid bit and stalls any fetch meanwhile. The first cached fetch afterwards misses.
- R9: While a transaction is pending, a held fetch request sees `fetch_stall` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch request, held until a cycle with the stall low |
| fetch_addr | input | 32 | Byte address of the instruction |
| fetch_uncached | input | 1 | From address decode: bypass the array for this fetch |
| fetch_stall | output | 1 | Fetch cannot complete this cycle |
| fetch_rdata | output | 32 | Instruction word, valid when request is high and stall is low |
| fetch_berr | output | 1 | Bus error on the returned word, valid with rdata |
| bus_req | output | 1 | Read command valid |
| bus_gnt | input | 1 | Command accepted this cycle |
| bus_addr | output | 32 | Command start address |
| bus_len | output | log2(WORDS)+1 | Number of words to read |
| bus_rsp_val | input | 1 | Response beat valid |
| bus_rsp_data | input | 32 | Response beat data |
| bus_rsp_err | input | 1 | Response beat error flag |

## Verification
Two pairs of events can fall in the same cycle. In the first, the reset sweep is still clearing valid bits when a fetch request arrives. The bench provokes this by asserting a fetch right after reset is released, and it judges the result by a stall that covers the sweep and by the bus command that follows. In the second, the fill commit coincides with an error flag on the line's last beat. The bench injects the error on the final beat and expects `fetch_berr` together with a fresh miss on the retry. Expected words come from an arithmetic memory function in the bench, and a small configuration is swept across every set, way and word.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int IC_AW = 32;
  localparam int IC_DW = 32;

  typedef enum logic [2:0] {
    IC_SWEEP,
    IC_LOOK,
    IC_CMD,
    IC_RSP,
    IC_DONE
  } ic_state_e;
endpackage

// File: rtl/ic_tag_array.sv
module ic_tag_array #(
  parameter int SETS  = 32,
  parameter int WAYS  = 4,
  parameter int TW    = 22,
  localparam int SB   = $clog2(SETS),
  localparam int WYB  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic           clk,
  input  logic           clr_en,
  input  logic [SB-1:0]  clr_set,
  input  logic [SB-1:0]  lk_set,
  input  logic [TW-1:0]  lk_tag,
  output logic           hit,
  output logic [WYB-1:0] hit_way,
  output logic [WYB-1:0] victim,
  input  logic           inv_en,
  input  logic [SB-1:0]  inv_set,
  input  logic [WYB-1:0] inv_way,
  input  logic           fil_en,
  input  logic [SB-1:0]  fil_set,
  input  logic [WYB-1:0] fil_way,
  input  logic [TW-1:0]  fil_tag
);
  logic [WAYS-1:0] vld  [SETS];
  logic [TW-1:0]   tagm [SETS][WAYS];
  logic [WYB-1:0]  rrp  [SETS];
  logic [WAYS-1:0] hv;

  function automatic logic [WYB-1:0] rr_next(input logic [WYB-1:0] p);
    return (p == WYB'(WAYS - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hv[w] = vld[lk_set][w] && (tagm[lk_set][w] == lk_tag);
  end

  assign hit    = |hv;
  assign victim = rrp[lk_set];

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hv[w]) hit_way = WYB'(w);
  end

  always_ff @(posedge clk) begin
    if (clr_en) begin
      vld[clr_set] <= '0;
      rrp[clr_set] <= '0;
    end else begin
      if (inv_en) vld[inv_set][inv_way] <= 1'b0;
      if (fil_en) begin
        vld[fil_set][fil_way]  <= 1'b1;
        tagm[fil_set][fil_way] <= fil_tag;
        rrp[fil_set]           <= rr_next(rrp[fil_set]);
      end
    end
  end
endmodule

// File: rtl/ic_data_array.sv
module ic_data_array #(
  parameter int SETS  = 32,
  parameter int WAYS  = 4,
  parameter int WORDS = 8,
  localparam int DEPTH = SETS * WAYS * WORDS,
  localparam int AB    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AB-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AB-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache
  import ic_pkg::*;
#(
  parameter int SETS  = 32,
  parameter int WORDS = 8,
  parameter int WAYS  = 4,
  localparam int OB   = $clog2(WORDS),
  localparam int SB   = $clog2(SETS),
  localparam int TW   = IC_AW - 2 - OB - SB,
  localparam int WYB  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int LW   = $clog2(WORDS) + 1,
  localparam int AB   = $clog2(SETS * WAYS * WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_req,
  input  logic [31:0]      fetch_addr,
  input  logic             fetch_uncached,
  output logic             fetch_stall,
  output logic [31:0]      fetch_rdata,
  output logic             fetch_berr,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic [31:0]      bus_addr,
  output logic [LW-1:0]    bus_len,
  input  logic             bus_rsp_val,
  input  logic [31:0]      bus_rsp_data,
  input  logic             bus_rsp_err
);
  function automatic logic [OB-1:0] f_word(input logic [31:0] a);
    return a[OB+1:2];
  endfunction
  function automatic logic [SB-1:0] f_set(input logic [31:0] a);
    return a[OB+SB+1:OB+2];
  endfunction
  function automatic logic [TW-1:0] f_tag(input logic [31:0] a);
    return a[31:OB+SB+2];
  endfunction
  function automatic logic [31:0] f_line(input logic [31:0] a);
    return {a[31:OB+2], {(OB+2){1'b0}}};
  endfunction
  function automatic logic [AB-1:0] f_flat(input logic [SB-1:0] s,
                                           input logic [WYB-1:0] w,
                                           input logic [OB-1:0] o);
    return AB'((int'(s) * WAYS + int'(w)) * WORDS + int'(o));
  endfunction

  ic_state_e      st;
  logic [SB-1:0]  swp;
  logic [31:0]    ra;
  logic           r_unc;
  logic [WYB-1:0] r_way;
  logic [OB-1:0]  beat;
  logic           eacc;
  logic [31:0]    wbuf;

  logic           hit;
  logic [WYB-1:0] hit_way;
  logic [WYB-1:0] victim;
  logic [31:0]    rd_hit;

  // named internal events, also observed by the checker
  logic in_sweep, in_rsp, ev_hit, ev_miss, ev_unc, ev_beat, ev_last, ev_fill;
  logic unused_bits;

  assign in_sweep = (st == IC_SWEEP);
  assign in_rsp   = (st == IC_RSP);
  assign ev_hit   = (st == IC_LOOK) && fetch_req && !fetch_uncached && hit;
  assign ev_miss  = (st == IC_LOOK) && fetch_req && !fetch_uncached && !hit;
  assign ev_unc   = (st == IC_LOOK) && fetch_req && fetch_uncached;
  assign ev_beat  = in_rsp && bus_rsp_val;
  assign ev_last  = ev_beat && (r_unc || beat == OB'(WORDS - 1));
  assign ev_fill  = ev_last && !r_unc && !(eacc || bus_rsp_err);
  assign unused_bits = ^{fetch_addr[1:0], ra[1:0]};

  ic_tag_array #(.SETS(SETS), .WAYS(WAYS), .TW(TW)) u_tags (
    .clk     (clk),
    .clr_en  (in_sweep),
    .clr_set (swp),
    .lk_set  (f_set(fetch_addr)),
    .lk_tag  (f_tag(fetch_addr)),
    .hit     (hit),
    .hit_way (hit_way),
    .victim  (victim),
    .inv_en  (ev_miss),
    .inv_set (f_set(fetch_addr)),
    .inv_way (victim),
    .fil_en  (ev_fill),
    .fil_set (f_set(ra)),
    .fil_way (r_way),
    .fil_tag (f_tag(ra))
  );

  ic_data_array #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS)) u_data (
    .clk   (clk),
    .we    (ev_beat && !r_unc),
    .waddr (f_flat(f_set(ra), r_way, beat)),
    .wdata (bus_rsp_data),
    .raddr (f_flat(f_set(fetch_addr), hit_way, f_word(fetch_addr))),
    .rdata (rd_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IC_SWEEP;
      swp   <= '0;
      ra    <= '0;
      r_unc <= 1'b0;
      r_way <= '0;
      beat  <= '0;
      eacc  <= 1'b0;
      wbuf  <= '0;
    end else begin
      unique case (st)
        IC_SWEEP: begin
          swp <= swp + 1'b1;
          if (swp == SB'(SETS - 1)) st <= IC_LOOK;
        end
        IC_LOOK: begin
          if (ev_miss || ev_unc) begin
            ra    <= fetch_addr;
            r_unc <= fetch_uncached;
            r_way <= victim;
            st    <= IC_CMD;
          end
        end
        IC_CMD: begin
          if (bus_gnt) begin
            beat <= '0;
            eacc <= 1'b0;
            st   <= IC_RSP;
          end
        end
        IC_RSP: begin
          if (bus_rsp_val) begin
            eacc <= eacc || bus_rsp_err;
            if (r_unc || beat == f_word(ra)) wbuf <= bus_rsp_data;
            if (ev_last) st <= IC_DONE;
            else         beat <= beat + 1'b1;
          end
        end
        IC_DONE: st <= IC_LOOK;
        default: st <= IC_LOOK;
      endcase
    end
  end

  assign bus_req     = (st == IC_CMD);
  assign bus_addr    = r_unc ? {ra[31:2], 2'b00} : f_line(ra);
  assign bus_len     = r_unc ? LW'(1) : LW'(WORDS);
  assign fetch_stall = fetch_req && !ev_hit && (st != IC_DONE);
  assign fetch_rdata = (st == IC_DONE) ? wbuf : rd_hit;
  assign fetch_berr  = (st == IC_DONE) && eacc;
endmodule

// File: rtl/ifetch_cache_chk.sv
module ifetch_cache_chk #(
  parameter int WORDS = 8,
  localparam int OB   = $clog2(WORDS),
  localparam int LW   = $clog2(WORDS) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_req,
  input logic          fetch_stall,
  input logic          fetch_berr,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic [31:0]   bus_addr,
  input logic [LW-1:0] bus_len,
  input logic          ev_hit,
  input logic          ev_miss,
  input logic          ev_unc,
  input logic          in_sweep,
  input logic          in_rsp
);
  // R1
  p_hit_no_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |-> !fetch_stall);

  // R2
  p_line_cmd_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_len != LW'(1)) |-> (bus_len == LW'(WORDS) && bus_addr[OB+1:0] == '0));

  // R2, R3
  p_cmd_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(ev_miss || ev_unc));

  // R3
  p_single_word_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_len == LW'(1)) |-> bus_addr[1:0] == 2'b00);

  // R4
  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_len)));

  // R4
  p_one_txn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt) |=> !bus_req);

  // R4
  p_no_cmd_in_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_rsp |-> !bus_req);

  // R7
  p_err_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_berr |-> !fetch_stall);

  // R8
  p_sweep_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sweep && fetch_req) |-> fetch_stall);

  // R9
  p_busy_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_rsp || bus_req) && fetch_req) |-> fetch_stall);
endmodule

bind ifetch_cache ifetch_cache_chk #(.WORDS(WORDS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_req   (fetch_req),
  .fetch_stall (fetch_stall),
  .fetch_berr  (fetch_berr),
  .bus_req     (bus_req),
  .bus_gnt     (bus_gnt),
  .bus_addr    (bus_addr),
  .bus_len     (bus_len),
  .ev_hit      (ev_hit),
  .ev_miss     (ev_miss),
  .ev_unc      (ev_unc),
  .in_sweep    (in_sweep),
  .in_rsp      (in_rsp)
);

// File: tb/test_ifetch_cache.sv
`timescale 1ns/1ps
module test_ifetch_cache;
  localparam int SETS  = 4;
  localparam int WORDS = 4;
  localparam int WAYS  = 2;
  localparam int LW    = $clog2(WORDS) + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fetch_req, fetch_uncached;
  logic [31:0]   fetch_addr;
  logic          fetch_stall, fetch_berr;
  logic [31:0]   fetch_rdata;
  logic          bus_req, bus_gnt;
  logic [31:0]   bus_addr;
  logic [LW-1:0] bus_len;
  logic          bus_rsp_val, bus_rsp_err;
  logic [31:0]   bus_rsp_data;

  int checks = 0, errors = 0, cyc_total = 0;
  bit finished = 0;
  int txn_cnt = 0, last_len = 0, gnt_delay = 0;
  logic [31:0] last_addr = '0, err_addr = '0;
  bit gap_on = 0, err_en = 0;
  int err_beat = 0;

  always #2 clk = ~clk;

  ifetch_cache #(.SETS(SETS), .WORDS(WORDS), .WAYS(WAYS)) i_ifetch_cache (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_uncached(fetch_uncached),
    .fetch_stall(fetch_stall), .fetch_rdata(fetch_rdata), .fetch_berr(fetch_berr),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_len(bus_len),
    .bus_rsp_val(bus_rsp_val), .bus_rsp_data(bus_rsp_data), .bus_rsp_err(bus_rsp_err)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return a * 32'h9E3779B1 + 32'h0BAD_F00D;
  endfunction

  // layout for this configuration: word [3:2], set [5:4], tag from bit 6 up
  function automatic logic [31:0] ad(input int t, input int s, input int w);
    return 32'h0001_0000 + 32'(t * 64) + 32'(s * 16) + 32'(w * 4);
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic fetch(input logic [31:0] a, input bit unc,
                       output logic [31:0] d, output bit e, output int cyc);
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = a; fetch_uncached = unc;
    #1;
    cyc = 0;
    while (fetch_stall && cyc < 1000) begin
      @(negedge clk); #1; cyc++;
    end
    d = fetch_rdata; e = fetch_berr;
    @(posedge clk); #1;
    fetch_req = 1'b0;
  endtask

  // bus responder
  initial begin
    logic [31:0] ca;
    int cl;
    bus_gnt = 0; bus_rsp_val = 0; bus_rsp_data = '0; bus_rsp_err = 0;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && bus_req) begin
        repeat (gnt_delay) @(negedge clk);
        bus_gnt = 1; ca = bus_addr; cl = int'(bus_len);
        txn_cnt++; last_addr = ca; last_len = cl;
        @(negedge clk);
        bus_gnt = 0;
        for (int k = 0; k < cl; k++) begin
          if (gap_on && (k % 2 == 1)) @(negedge clk);
          chk(bus_req == 1'b0, "R4 command raised while response pending", 32'(bus_req), 32'd0);
          bus_rsp_val  = 1;
          bus_rsp_data = memf(ca + 32'(4 * k));
          bus_rsp_err  = err_en && (ca == err_addr) && (k == err_beat);
          @(negedge clk);
          bus_rsp_val = 0; bus_rsp_err = 0;
        end
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc_total++;
      if (cyc_total > 100000 && !finished) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc_total, 100000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    bit e;
    int cyc, t0;
    rst_n = 0; fetch_req = 0; fetch_addr = '0; fetch_uncached = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(bus_req == 1'b0, "R4 reset: no command", 32'(bus_req), 32'd0);
    @(negedge clk);
    rst_n = 1;

    // R8: fetch held during the sweep; first fetch must miss
    fetch_req = 1; fetch_addr = ad(0, 0, 0); fetch_uncached = 0;
    #1;
    chk(fetch_stall == 1'b1, "R8 stall during sweep", 32'(fetch_stall), 32'd1);
    fetch(ad(0, 0, 0), 0, d, e, cyc);
    chk(cyc >= SETS, "R8 stall covers sweep", 32'(cyc), 32'(SETS));
    chk(txn_cnt == 1, "R8 first fetch misses", 32'(txn_cnt), 32'd1);
    chk(d == memf(ad(0, 0, 0)), "R5 first fill word", d, memf(ad(0, 0, 0)));

    // fill every way of every set, with varied grant delays and beat gaps
    for (int t = 0; t < WAYS; t++) begin
      for (int s = 0; s < SETS; s++) begin
        gnt_delay = s % 3; gap_on = (t == 1);
        t0 = txn_cnt;
        fetch(ad(t, s, (s + t) % WORDS), 0, d, e, cyc);
        chk(d == memf(ad(t, s, (s + t) % WORDS)), "R5 requested word after fill", d, memf(ad(t, s, (s + t) % WORDS)));
        if (t == 0 && s == 0) begin
          chk(txn_cnt == t0 && cyc == 0, "R1 already filled line hits", 32'(txn_cnt - t0), 32'd0);
        end else begin
          chk(txn_cnt == t0 + 1, "R2 miss issues one command", 32'(txn_cnt - t0), 32'd1);
          chk(last_addr == ad(t, s, 0), "R2 line aligned address", last_addr, ad(t, s, 0));
          chk(last_len == WORDS, "R2 burst length", 32'(last_len), 32'(WORDS));
          chk(cyc >= WORDS, "R9 stall held across burst", 32'(cyc), 32'(WORDS));
          chk(e == 1'b0, "R7 no error flagged", 32'(e), 32'd0);
        end
      end
    end

    // every word of every line now hits
    gap_on = 0; gnt_delay = 0;
    t0 = txn_cnt;
    for (int t = 0; t < WAYS; t++)
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WORDS; w++) begin
          fetch(ad(t, s, w), 0, d, e, cyc);
          chk(cyc == 0, "R1 hit without stall", 32'(cyc), 32'd0);
          chk(d == memf(ad(t, s, w)), "R5 word order in line", d, memf(ad(t, s, w)));
        end
    chk(txn_cnt == t0, "R1 hits issue no command", 32'(txn_cnt - t0), 32'd0);

    // R6: set 2 holds tags 0 (way0) and 1 (way1), pointer at way 0
    t0 = txn_cnt;
    fetch(ad(2, 2, 1), 0, d, e, cyc);
    chk(txn_cnt == t0 + 1, "R6 new tag misses", 32'(txn_cnt - t0), 32'd1);
    fetch(ad(1, 2, 0), 0, d, e, cyc);
    chk(txn_cnt == t0 + 1 && d == memf(ad(1, 2, 0)), "R6 tag1 survives (way0 evicted)", 32'(txn_cnt - t0), 32'd1);
    fetch(ad(0, 2, 3), 0, d, e, cyc);
    chk(txn_cnt == t0 + 2, "R6 tag0 was evicted", 32'(txn_cnt - t0), 32'd2);
    fetch(ad(2, 2, 0), 0, d, e, cyc);
    chk(txn_cnt == t0 + 2 && d == memf(ad(2, 2, 0)), "R6 tag2 kept (way1 evicted)", 32'(txn_cnt - t0), 32'd2);
    fetch(ad(1, 2, 2), 0, d, e, cyc);
    chk(txn_cnt == t0 + 3, "R6 tag1 was evicted", 32'(txn_cnt - t0), 32'd3);

    // R3: uncached fetch of a cached address goes to the bus as one word
    t0 = txn_cnt;
    fetch(ad(1, 1, 2), 1, d, e, cyc);
    chk(txn_cnt == t0 + 1, "R3 uncached issues command", 32'(txn_cnt - t0), 32'd1);
    chk(last_len == 1, "R3 single word length", 32'(last_len), 32'd1);
    chk(last_addr == ad(1, 1, 2), "R3 word address", last_addr, ad(1, 1, 2));
    chk(d == memf(ad(1, 1, 2)) && cyc > 0, "R3 uncached data with stall", d, memf(ad(1, 1, 2)));
    fetch(ad(3, 3, 1), 1, d, e, cyc);
    chk(d == memf(ad(3, 3, 1)), "R3 uncached data new address", d, memf(ad(3, 3, 1)));
    t0 = txn_cnt;
    fetch(ad(3, 3, 1), 0, d, e, cyc);
    chk(txn_cnt == t0 + 1 && last_len == WORDS, "R3 uncached read filled nothing", 32'(txn_cnt - t0), 32'd1);

    // R7: error on the final beat of a line fill
    err_en = 1; err_addr = ad(3, 0, 0); err_beat = WORDS - 1;
    fetch(ad(3, 0, 1), 0, d, e, cyc);
    chk(e == 1'b1, "R7 error returned", 32'(e), 32'd1);
    chk(cyc > 0, "R7 stall before error return", 32'(cyc), 32'd1);
    err_en = 0;
    t0 = txn_cnt;
    fetch(ad(3, 0, 1), 0, d, e, cyc);
    chk(txn_cnt == t0 + 1, "R7 line left invalid", 32'(txn_cnt - t0), 32'd1);
    chk(e == 1'b0 && d == memf(ad(3, 0, 1)), "R7 retry data", d, memf(ad(3, 0, 1)));
    fetch(ad(3, 0, 1), 0, d, e, cyc);
    chk(cyc == 0, "R1 retried line hits", 32'(cyc), 32'd0);

    // R7: error on an uncached single word
    err_en = 1; err_addr = ad(0, 1, 3); err_beat = 0;
    fetch(ad(0, 1, 3), 1, d, e, cyc);
    chk(e == 1'b1, "R7 uncached error returned", 32'(e), 32'd1);
    err_en = 0;

    repeat (3) @(posedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule